// File: doc/BRIEF.md
# Single-Port FIFO Controller with Ready and Threshold Flags

This block manages one 36-bit wide, 256-word FIFO from the side of a single clocked data port. A four-signal port decode (active-low select, write/read direction, enable, and a mailbox select) becomes write and read strobes. Each strobe is qualified by the matching ready flag, so an access the FIFO cannot take has no effect. Reads are fall-through: the oldest stored word is always present on the data output while output-ready is high, and a read strobe moves past it.

The data output has an enable. It is asserted only while the port is selected in the read direction. The reset input is asynchronous and active low. While reset is low, every flag is forced to its defined level. The release of reset passes through a two-stage synchroniser, and input-ready then opens two cycles later. Almost-empty and almost-full are active low. They compare the stored word count and the free space with two threshold inputs supplied from outside. A mailbox flag output is present and sits at its reset level, because mailbox transfers are not part of this block.

Top module: `fifo_port`

## Requirements
- R1: A word on `dIn` is stored at the tail on a rising edge only when `csN`=0, `wrRd`=1, `en`=1, `mbSel`=0 and `inReady`=1.
- R2: A read on a rising edge happens only when `csN`=0, `wrRd`=0, `en`=1, `mbSel`=0 and `outReady`=1. While `outReady`=1, `dOut` shows the oldest stored word, and the read advances to the next word.
- R3: `dOutEn` is 1 exactly when `csN`=0 and `wrRd`=0, whatever the other inputs are.
- R4: While `rstN`=0 (taking effect without a clock), `inReady`=0, `outReady`=0, `almostEmptyN`=0, `almostFullN`=1 and `mailFlagN`=1, and all stored words are discarded.
- R5: After `rstN` rises between clock edges with the FIFO empty, `inReady` stays 0 through the third rising edge and becomes 1 at the fourth rising edge: two synchroniser edges, then two edges of delay.
- R6: After reset release, `almostEmptyN`=0 exactly when the stored word count is at or below `offEmpty`.
- R7: After reset release, `almostFullN`=0 exactly when the free space (256 minus the count) is at or below `offFull`.
- R8: `outReady`=1 exactly when at least one word is stored. It falls at the edge that reads the last word, and a read attempted while it is 0 changes nothing.
- R9: `inReady`=0 while 256 words are stored. Writes attempted then leave the count and the contents unchanged.
- R10: An access with `mbSel`=1, `en`=0 or `csN`=1 changes neither the count nor the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low port select |
| wrRd | input | 1 | Direction: 1 write, 0 read |
| en | input | 1 | Access enable |
| mbSel | input | 1 | Mailbox select; blocks FIFO access when 1 |
| offEmpty | input | 8 | Almost-empty threshold in words |
| offFull | input | 8 | Almost-full threshold in free words |
| dIn | input | 36 | Write data |
| dOut | output | 36 | Oldest stored word (fall-through) |
| dOutEn | output | 1 | Output drive enable (0 means high impedance) |
| inReady | output | 1 | FIFO can accept a write |
| outReady | output | 1 | A word is available to read |
| almostEmptyN | output | 1 | Active-low almost-empty flag |
| almostFullN | output | 1 | Active-low almost-full flag |
| mailFlagN | output | 1 | Mailbox flag, held at its reset level |

## Verification
The FIFO is filled word by word from empty to all 256 locations and drained back, with the flags checked at every count. This separates off-by-one threshold comparisons from correct ones, and shows where full and empty sit. With the count fixed at a middle value, both thresholds are swept over all 256 values, which isolates the comparators from the counting. Accesses blocked by each decode input in turn, writes at full, and a read when empty must all leave the contents unchanged, which is confirmed when the words are drained later. Two resets are applied: one from power-up, with every edge after release checked, and one in the middle of operation. Together they pin down the input-ready delay and show that old contents are lost.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;
  // Strobes passed from the port control to the storage datapath.
  typedef struct packed {
    logic push;   // store dIn at the tail
    logic pop;    // retire the head word
    logic flush;  // hold pointers and count at zero
  } fifoStrobe_t;
endpackage

// File: rtl/fifo_port_dp.sv
module fifo_port_dp
  import fifo_port_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  wordCount
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      wordCount <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      wordCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      unique case ({strobe.push, strobe.pop})
        2'b10:   wordCount <= wordCount + 1'b1;
        2'b01:   wordCount <= wordCount - 1'b1;
        default: wordCount <= wordCount;
      endcase
    end
  end

  assign rdData = store[rdPtr];
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl
  import fifo_port_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int OFF_W       = $clog2(DEPTH),
  parameter int CNT_W       = $clog2(DEPTH) + 1,
  parameter int SYNC_STAGES = 2,
  parameter int READY_DLY   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrRd,
  input  logic             en,
  input  logic             mbSel,
  input  logic [OFF_W-1:0] offEmpty,
  input  logic [OFF_W-1:0] offFull,
  input  logic [CNT_W-1:0] wordCount,
  output fifoStrobe_t      strobe,
  output logic             dOutEn,
  output logic             inReady,
  output logic             outReady,
  output logic             almostEmptyN,
  output logic             almostFullN,
  output logic             mailFlagN
);
  localparam int DLY_W = $clog2(READY_DLY + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // Reset release synchroniser
  logic [SYNC_STAGES-1:0] syncQ;
  logic relDone;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= 1'b1;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign relDone = syncQ[SYNC_STAGES-1];

  // Input-ready opening delay
  logic [DLY_W-1:0] dlyCnt;
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
      armed  <= 1'b0;
    end else if (relDone && !armed) begin
      if (dlyCnt == DLY_W'(READY_DLY - 1)) armed <= 1'b1;
      else                                 dlyCnt <= dlyCnt + 1'b1;
    end
  end

  // Occupancy and flags
  logic isFull, isEmpty;
  logic [CNT_W-1:0] freeSpace;

  assign isFull    = (wordCount == FULL_CNT);
  assign isEmpty   = (wordCount == '0);
  assign freeSpace = FULL_CNT - wordCount;

  assign inReady      = armed && !isFull;
  assign outReady     = relDone && !isEmpty;
  assign almostEmptyN = !(wordCount <= CNT_W'(offEmpty));
  assign almostFullN  = !(relDone && (freeSpace <= CNT_W'(offFull)));
  assign mailFlagN    = 1'b1;

  // Port decode
  logic portHit;
  assign portHit      = !csN && en && !mbSel;
  assign strobe.push  = portHit && wrRd && inReady;
  assign strobe.pop   = portHit && !wrRd && outReady;
  assign strobe.flush = !relDone;
  assign dOutEn       = !csN && !wrRd;
endmodule

// File: rtl/fifo_port.sv
module fifo_port
  import fifo_port_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  parameter int OFF_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrRd,
  input  logic              en,
  input  logic              mbSel,
  input  logic [OFF_W-1:0]  offEmpty,
  input  logic [OFF_W-1:0]  offFull,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              inReady,
  output logic              outReady,
  output logic              almostEmptyN,
  output logic              almostFullN,
  output logic              mailFlagN
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrobe_t      strobe;
  logic [CNT_W-1:0] wordCount;

  fifo_port_ctrl #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .CNT_W(CNT_W),
    .SYNC_STAGES(2), .READY_DLY(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrRd(wrRd), .en(en), .mbSel(mbSel),
    .offEmpty(offEmpty), .offFull(offFull), .wordCount(wordCount),
    .strobe(strobe), .dOutEn(dOutEn), .inReady(inReady), .outReady(outReady),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN), .mailFlagN(mailFlagN)
  );

  fifo_port_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(dIn),
    .rdData(dOut), .wordCount(wordCount)
  );
endmodule

// File: rtl/fifo_port_chk.sv
module fifo_port_chk #(
  parameter int DATA_W = 36,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              en,
  input logic              mbSel,
  input logic [DATA_W-1:0] dOut,
  input logic              inReady,
  input logic              outReady,
  input logic              almostEmptyN,
  input logic              almostFullN,
  input logic              mailFlagN
);
  logic idle;
  assign idle = csN || !en || mbSel;

  // R4: flags at their reset levels while reset is held
  p_reset_flags_r4: assert property (@(posedge clk)
    !rstN |-> (!inReady && !outReady && !almostEmptyN && almostFullN && mailFlagN));

  // R5: input-ready can only open after three edges with reset released
  p_ready_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> ($past(rstN, 1) && $past(rstN, 2) && $past(rstN, 3)));

  // R6: nothing to read implies almost-empty asserted
  p_empty_ae_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !almostEmptyN);

  // R7: full (data present, no room) implies almost-full asserted
  p_full_af_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && !inReady) |-> !almostFullN);

  // R10: a blocked access leaves output-ready unchanged
  p_idle_or_r10: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> $stable(outReady));

  // R10: a blocked access leaves the head word unchanged
  p_idle_dout_r10: assert property (@(posedge clk) disable iff (!rstN)
    (idle && outReady) |=> $stable(dOut));
endmodule

bind fifo_port fifo_port_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .en(en), .mbSel(mbSel), .dOut(dOut),
  .inReady(inReady), .outReady(outReady), .almostEmptyN(almostEmptyN),
  .almostFullN(almostFullN), .mailFlagN(mailFlagN)
);

// File: tb/fifo_port_bench.sv
module fifo_port_bench;
  localparam int PERIOD = 10;
  localparam int DW     = 36;
  localparam int DEPTH  = 256;
  localparam int OW     = 8;

  logic clk = 1'b0;
  logic rstN, csN, wrRd, en, mbSel;
  logic [OW-1:0] offEmpty, offFull;
  logic [DW-1:0] dIn, dOut;
  logic dOutEn, inReady, outReady, almostEmptyN, almostFullN, mailFlagN;

  always #(PERIOD/2) clk = ~clk;

  fifo_port u_fifo_port (
    .clk(clk), .rstN(rstN), .csN(csN), .wrRd(wrRd), .en(en), .mbSel(mbSel),
    .offEmpty(offEmpty), .offFull(offFull), .dIn(dIn), .dOut(dOut),
    .dOutEn(dOutEn), .inReady(inReady), .outReady(outReady),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN), .mailFlagN(mailFlagN)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Reference model
  logic [DW-1:0] mq [DEPTH];
  int mHead = 0, mTail = 0, mCnt = 0;
  bit mArmed = 0;
  int wordSeq = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    logic [15:0] a, b;
    a = 16'(k * 7 + 1);
    b = 16'(k) ^ 16'h5A5A;
    return {4'(k) ^ 4'h5, a, b};
  endfunction

  task automatic checkAll();
    check("R9 inReady", DW'(inReady), DW'(mArmed && mCnt < DEPTH));
    check("R8 outReady", DW'(outReady), DW'(mCnt > 0));
    check("R6 almostEmptyN", DW'(almostEmptyN), DW'(!(mCnt <= int'(offEmpty))));
    check("R7 almostFullN", DW'(almostFullN), DW'(!((DEPTH - mCnt) <= int'(offFull))));
    if (mCnt > 0) check("R2 dOut head", dOut, mq[mHead]);
  endtask

  // One access: drive just after a falling edge, check after the next falling edge
  task automatic step(input logic c, input logic w, input logic e, input logic m,
                      input logic [DW-1:0] d);
    bit acc;
    csN = c; wrRd = w; en = e; mbSel = m; dIn = d;
    acc = !c && e && !m && (w ? (mArmed && mCnt < DEPTH) : (mCnt > 0));
    @(posedge clk);
    if (acc && w) begin
      mq[mTail] = d; mTail = (mTail + 1) % DEPTH; mCnt++;
    end else if (acc && !w) begin
      mHead = (mHead + 1) % DEPTH; mCnt--;
    end
    @(negedge clk);
    csN = 1'b1; en = 1'b0; mbSel = 1'b0;
    #1;
    checkAll();
  endtask

  task automatic pushWord();
    step(1'b0, 1'b1, 1'b1, 1'b0, pat(wordSeq));
    wordSeq++;
  endtask

  task automatic popWord();
    step(1'b0, 1'b0, 1'b1, 1'b0, '0);
  endtask

  // Reset from a falling edge, hold, release mid-cycle, check each edge after
  task automatic doReset(input int holdEdges);
    @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    mArmed = 0; mCnt = 0; mHead = 0; mTail = 0;
    check("R4 inReady in reset", DW'(inReady), DW'(0));
    check("R4 outReady in reset", DW'(outReady), DW'(0));
    check("R4 almostEmptyN in reset", DW'(almostEmptyN), DW'(0));
    check("R4 almostFullN in reset", DW'(almostFullN), DW'(1));
    check("R4 mailFlagN in reset", DW'(mailFlagN), DW'(1));
    repeat (holdEdges) @(posedge clk);
    @(negedge clk);
    #2 rstN = 1'b1;
    for (int e = 1; e <= 6; e++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R5 inReady after release", DW'(inReady), DW'(e >= 4));
      check("R4 outReady after release", DW'(outReady), DW'(0));
    end
    mArmed = 1;
    checkAll();
  endtask

  initial begin
    #(PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; wrRd = 1'b1; en = 1'b0; mbSel = 1'b0;
    dIn = '0; offEmpty = 8'd5; offFull = 8'd7;
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    check("R4 inReady at power-up", DW'(inReady), DW'(0));
    check("R4 outReady at power-up", DW'(outReady), DW'(0));
    check("R4 almostEmptyN at power-up", DW'(almostEmptyN), DW'(0));
    check("R4 almostFullN at power-up", DW'(almostFullN), DW'(1));
    check("R4 mailFlagN at power-up", DW'(mailFlagN), DW'(1));
    #1 rstN = 1'b1;
    for (int e = 1; e <= 6; e++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      check("R5 inReady after power-up release", DW'(inReady), DW'(e >= 4));
    end
    mArmed = 1;

    // R3: output enable over select/direction, other inputs idle and active
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++)
        for (int e = 0; e < 2; e++) begin
          csN = c[0]; wrRd = w[0]; en = 1'b0; mbSel = e[0];
          #1;
          check("R3 dOutEn", DW'(dOutEn), DW'(c == 0 && w == 0));
        end
    csN = 1'b1; wrRd = 1'b1; mbSel = 1'b0;
    @(negedge clk); #1;

    // R1, R6, R7, R9: fill from empty to full
    for (int k = 0; k < DEPTH; k++) pushWord();
    check("R9 inReady at full", DW'(inReady), DW'(0));
    // R9: writes at full are ignored
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1, 1'b0, ~pat(k));

    // R2, R8: drain down to ten words
    for (int k = 0; k < DEPTH - 10; k++) popWord();

    // R6, R7: threshold sweeps at a fixed count of ten
    for (int v = 0; v < 256; v++) begin
      offEmpty = OW'(v); offFull = OW'(v);
      #1;
      check("R6 almostEmptyN sweep", DW'(almostEmptyN), DW'(!(10 <= v)));
      check("R7 almostFullN sweep", DW'(almostFullN), DW'(!((DEPTH - 10) <= v)));
    end
    offEmpty = 8'd12; offFull = 8'd250;
    #1;

    // R10: blocked writes and reads
    step(1'b0, 1'b1, 1'b1, 1'b1, 36'hBAD000001);
    step(1'b0, 1'b1, 1'b0, 1'b0, 36'hBAD000002);
    step(1'b1, 1'b1, 1'b1, 1'b0, 36'hBAD000003);
    step(1'b0, 1'b0, 1'b1, 1'b1, '0);
    step(1'b0, 1'b0, 1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 1'b1, 1'b0, '0);

    // R1, R2: interleaved pattern
    for (int k = 0; k < 40; k++) begin
      pushWord();
      if (k % 3 != 0) popWord();
    end

    // R8: drain to empty, then a read when empty
    while (mCnt > 0) popWord();
    check("R8 outReady low after last read", DW'(outReady), DW'(0));
    popWord();
    pushWord();
    check("R1 first word after empty", dOut, pat(wordSeq - 1));

    // R4: reset in the middle of operation discards contents
    pushWord(); pushWord();
    doReset(4);
    check("R4 outReady after mid reset", DW'(outReady), DW'(0));
    pushWord();
    check("R1 new word after mid reset", dOut, pat(wordSeq - 1));
    popWord();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule